// File: doc/BRIEF.md
# Fuse Macro Word Read Sequencer

This block reads one 32-bit word out of a one-time-programmable fuse macro by driving the macro's raw control pins directly. A requester presents a word index together with a one-cycle start strobe. The sequencer first wakes the macro from deep standby. It then turns on the repair logic and the chip enable, and only after that presents the address. Next it gives the macro clock one high phase and one low phase, each lasting a programmable number of system clocks. It samples the data output and then powers the macro down in the reverse order.

The result comes back on a registered read-data output with a one-cycle done pulse. An index outside the 4096-word array is rejected with a one-cycle error pulse, and the macro pins are not touched at all. The programming, write and test pins of the macro are held inactive by this block at all times.

Top module: `otp_read_seq`

## Requirements
- R1: After reset, standby-release, repair-enable, chip-enable, macro clock and address are all 0, busy, done and error are 0, and read data is 0.
- R2: A start in idle with an in-range index raises standby-release one cycle later. Repair-enable follows on the next cycle, chip-enable on the cycle after that, and the address on the cycle after that, each earlier pin staying high.
- R3: With the address applied, the macro clock is high for exactly SETTLE cycles and then low for exactly SETTLE cycles. The macro clock is only ever high while standby-release, repair-enable and chip-enable are all high.
- R4: The word the macro returns for the index appears on read data and done pulses for one cycle, 8 + 2*SETTLE cycles after the start edge.
- R5: After sampling, chip-enable drops first, repair-enable one cycle later, and standby-release one cycle after that. Standby-release falls in the same cycle that done rises.
- R6: An index of 4096 or more gives a one-cycle error pulse one cycle after the start edge, with no done pulse. No macro pin changes and read data keeps its old value.
- R7: The program-mode, write-enable, test-mode, test-row and test-column outputs are 0 in every cycle.
- R8: Busy is high from the cycle after the start edge through the done or error cycle, and low afterwards. A start strobe raised while busy is ignored and changes neither the pin sequence nor the result.
- R9: Read data changes only at the capture of a valid read and holds its value while idle.
- R10: Indices 0 and 4095 are both read normally, with the 12-bit address equal to the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle read request |
| index_i | input | 16 | Word index to read |
| busy_o | output | 1 | Read or rejection in progress |
| done_o | output | 1 | One-cycle pulse, read data valid |
| err_o | output | 1 | One-cycle pulse, index out of range |
| rdata_o | output | 32 | Last captured word |
| fz_stby_n_o | output | 1 | Macro deep-standby pin, low = standby |
| fz_trim_o | output | 1 | Macro repair-enable pin |
| fz_ce_o | output | 1 | Macro chip-enable pin |
| fz_clk_o | output | 1 | Macro clock pin |
| fz_addr_o | output | 12 | Macro word address |
| fz_dout_i | input | 32 | Macro data output |
| fz_prog_o | output | 1 | Macro program-mode pin, held low |
| fz_we_o | output | 1 | Macro write-enable pin, held low |
| fz_tm_o | output | 1 | Macro test-mode pin, held low |
| fz_trow_o | output | 1 | Macro test-row pin, held low |
| fz_tcol_o | output | 1 | Macro test-column pin, held low |

## Verification
Each pin and status output is registered, so all of them move exactly one cycle after the sequencer state that asks for the change. Counting the start edge as cycle 0, the pins follow a fixed schedule:

- standby-release rises in cycle 1, repair-enable in cycle 2, chip-enable in cycle 3 and the address in cycle 4.
- the macro clock is high in cycles 5 to 4+S.
- captured data is visible from cycle 6+2S, and done comes in cycle 8+2S.
- a rejected index gives the error pulse in cycle 1.

The bench drives inputs and samples every output on the falling edge. For every cycle from 1 to 9+2S it compares the full pin vector against that schedule, so a change one cycle early or late shows up as a mismatch.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE,
    ST_TRIM,
    ST_ENABLE,
    ST_ADDR,
    ST_CLKH,
    ST_CLKL,
    ST_CAPT,
    ST_OFF_CE,
    ST_OFF_TRIM,
    ST_DONE,
    ST_ERR
  } seq_state_e;

endpackage

// File: rtl/otp_seq_timer.sv
module otp_seq_timer #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1);
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/otp_seq_ctrl.sv
module otp_seq_ctrl
  import otp_seq_pkg::*;
#(
  parameter int IW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [IW-1:0] index_i,
  input  logic          expired_i,
  output seq_state_e    state_o,
  output seq_state_e    nxt_o,
  output logic          load_o,
  output logic [AW-1:0] addr_o
);
  seq_state_e    state_q, nxt;
  logic [AW-1:0] addr_q;
  logic          oor;

  generate
    if (IW > AW) begin : g_range
      assign oor = (index_i[IW-1:AW] != '0);
    end else begin : g_norange
      assign oor = 1'b0;
    end
  endgenerate

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) nxt = oor ? ST_ERR : ST_WAKE;
      ST_WAKE:     nxt = ST_TRIM;
      ST_TRIM:     nxt = ST_ENABLE;
      ST_ENABLE:   nxt = ST_ADDR;
      ST_ADDR:     nxt = ST_CLKH;
      ST_CLKH:     if (expired_i) nxt = ST_CLKL;
      ST_CLKL:     if (expired_i) nxt = ST_CAPT;
      ST_CAPT:     nxt = ST_OFF_CE;
      ST_OFF_CE:   nxt = ST_OFF_TRIM;
      ST_OFF_TRIM: nxt = ST_DONE;
      ST_DONE:     nxt = ST_IDLE;
      ST_ERR:      nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  assign load_o = (nxt != state_q) && ((nxt == ST_CLKH) || (nxt == ST_CLKL));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= nxt;
      if (state_q == ST_IDLE && start_i) addr_q <= index_i[AW-1:0];
    end
  end

  assign state_o = state_q;
  assign nxt_o   = nxt;
  assign addr_o  = addr_q;
endmodule

// File: rtl/otp_seq_drive.sv
module otp_seq_drive
  import otp_seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_e    state_i,
  input  seq_state_e    nxt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dout_i,
  output logic          stby_n_o,
  output logic          trim_o,
  output logic          ce_o,
  output logic          mclk_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o
);
  logic awake_n, trim_n, ce_n, addr_on_n;

  always_comb begin
    awake_n   = nxt_i inside {ST_WAKE, ST_TRIM, ST_ENABLE, ST_ADDR, ST_CLKH,
                              ST_CLKL, ST_CAPT, ST_OFF_CE, ST_OFF_TRIM};
    trim_n    = nxt_i inside {ST_TRIM, ST_ENABLE, ST_ADDR, ST_CLKH, ST_CLKL,
                              ST_CAPT, ST_OFF_CE};
    ce_n      = nxt_i inside {ST_ENABLE, ST_ADDR, ST_CLKH, ST_CLKL, ST_CAPT};
    addr_on_n = nxt_i inside {ST_ADDR, ST_CLKH, ST_CLKL, ST_CAPT};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stby_n_o <= 1'b0;
      trim_o   <= 1'b0;
      ce_o     <= 1'b0;
      mclk_o   <= 1'b0;
      addr_o   <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      stby_n_o <= awake_n;
      trim_o   <= trim_n;
      ce_o     <= ce_n;
      mclk_o   <= (nxt_i == ST_CLKH);
      addr_o   <= addr_on_n ? addr_i : '0;
      busy_o   <= (nxt_i != ST_IDLE);
      done_o   <= (nxt_i == ST_DONE);
      err_o    <= (nxt_i == ST_ERR);
      if (state_i == ST_CAPT) rdata_o <= dout_i;
    end
  end
endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq
  import otp_seq_pkg::*;
#(
  parameter int IW     = 16,
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [IW-1:0] index_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic          fz_stby_n_o,
  output logic          fz_trim_o,
  output logic          fz_ce_o,
  output logic          fz_clk_o,
  output logic [AW-1:0] fz_addr_o,
  input  logic [DW-1:0] fz_dout_i,
  output logic          fz_prog_o,
  output logic          fz_we_o,
  output logic          fz_tm_o,
  output logic          fz_trow_o,
  output logic          fz_tcol_o
);
  seq_state_e    state, nxt;
  logic          load, expired;
  logic [AW-1:0] addr_q;

  otp_seq_ctrl #(.IW(IW), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .index_i(index_i),
    .expired_i(expired), .state_o(state), .nxt_o(nxt), .load_o(load),
    .addr_o(addr_q)
  );

  otp_seq_timer #(.SETTLE(SETTLE)) u_timer (
    .clk(clk), .rst(rst), .load_i(load), .expired_o(expired)
  );

  otp_seq_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk(clk), .rst(rst), .state_i(state), .nxt_i(nxt), .addr_i(addr_q),
    .dout_i(fz_dout_i), .stby_n_o(fz_stby_n_o), .trim_o(fz_trim_o),
    .ce_o(fz_ce_o), .mclk_o(fz_clk_o), .addr_o(fz_addr_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o)
  );

  // Programming and test pins are never used by a read.
  assign fz_prog_o = 1'b0;
  assign fz_we_o   = 1'b0;
  assign fz_tm_o   = 1'b0;
  assign fz_trow_o = 1'b0;
  assign fz_tcol_o = 1'b0;
endmodule

// File: rtl/otp_read_seq_chk.sv
module otp_read_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          stby_n,
  input logic          trim,
  input logic          ce,
  input logic          mclk,
  input logic          prog,
  input logic          we,
  input logic          tm,
  input logic          trow,
  input logic          tcol,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [DW-1:0] rdata
);
  AST_TRIM_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst) $rose(trim) |-> stby_n && !ce); // R2
  AST_CE_AFTER_TRIM: assert property (@(posedge clk) disable iff (rst) $rose(ce) |-> trim && stby_n && !mclk); // R2
  AST_CLK_WHEN_ON: assert property (@(posedge clk) disable iff (rst) mclk |-> ce && trim && stby_n); // R3
  AST_TRIM_OFF_AFTER_CE: assert property (@(posedge clk) disable iff (rst) $fell(trim) |-> !ce && stby_n); // R5
  AST_STBY_OFF_AFTER_TRIM: assert property (@(posedge clk) disable iff (rst) $fell(stby_n) |-> !trim && done); // R5
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (rst) err |-> !stby_n && !done && busy); // R6
  AST_SPARE_PINS_LOW: assert property (@(posedge clk) disable iff (rst) !(prog || we || tm || trow || tcol)); // R7
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done && !busy); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !busy |=> $stable(rdata)); // R9
endmodule

bind otp_read_seq otp_read_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .stby_n(fz_stby_n_o), .trim(fz_trim_o), .ce(fz_ce_o),
  .mclk(fz_clk_o), .prog(fz_prog_o), .we(fz_we_o), .tm(fz_tm_o),
  .trow(fz_trow_o), .tcol(fz_tcol_o), .busy(busy_o), .done(done_o),
  .err(err_o), .rdata(rdata_o)
);

// File: tb/test_otp_read_seq.sv
module test_otp_read_seq;
  localparam int S  = 3;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [15:0]   index = '0;
  logic          busy, done, err;
  logic [DW-1:0] rdata;
  logic          stby_n, trim, ce, mclk;
  logic [AW-1:0] addr;
  logic [DW-1:0] dout = '0;
  logic          prog, we, tm, trow, tcol;
  int            checks = 0;
  int            errors = 0;
  bit            finished = 0;

  always #4 clk = ~clk;

  otp_read_seq #(.SETTLE(S)) i_otp_read_seq (
    .clk(clk), .rst(rst), .start_i(start), .index_i(index), .busy_o(busy),
    .done_o(done), .err_o(err), .rdata_o(rdata), .fz_stby_n_o(stby_n),
    .fz_trim_o(trim), .fz_ce_o(ce), .fz_clk_o(mclk), .fz_addr_o(addr),
    .fz_dout_i(dout), .fz_prog_o(prog), .fz_we_o(we), .fz_tm_o(tm),
    .fz_trow_o(trow), .fz_tcol_o(tcol)
  );

  function automatic logic [DW-1:0] fuse_word(input logic [AW-1:0] a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  // Behavioural fuse array: data appears on a rising macro clock while powered.
  always @(posedge mclk) if (ce && trim && stby_n) dout <= fuse_word(addr);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] pins();
    return {rdata, 8'd0, stby_n, trim, ce, mclk, addr, busy, done, err, prog, we, tm, trow, tcol};
  endfunction

  // Full-cycle trace of one valid read; optional stray start while busy.
  task automatic read_trace(input logic [15:0] idx, input bit poke);
    logic [DW-1:0] old = rdata;
    logic [DW-1:0] w = fuse_word(idx[AW-1:0]);
    start = 1'b1; index = idx;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 9 + 2*S; c++) begin
      logic e_stby, e_trim, e_ce, e_clk, e_busy, e_done;
      logic [AW-1:0] e_addr;
      logic [DW-1:0] e_rd;
      string tag;
      e_stby = (c >= 1) && (c <= 7 + 2*S);
      e_trim = (c >= 2) && (c <= 6 + 2*S);
      e_ce   = (c >= 3) && (c <= 5 + 2*S);
      e_addr = ((c >= 4) && (c <= 5 + 2*S)) ? idx[AW-1:0] : '0;
      e_clk  = (c >= 5) && (c <= 4 + S);
      e_busy = (c <= 8 + 2*S);
      e_done = (c == 8 + 2*S);
      e_rd   = (c >= 6 + 2*S) ? w : old;
      if (c <= 4) tag = "R2 wake order";
      else if (c <= 5 + 2*S) tag = "R3 clock phases";
      else if (c <= 7 + 2*S) tag = "R5 shutdown order";
      else if (c == 8 + 2*S) tag = "R4 done and data";
      else tag = "R8 back to idle";
      if (poke) tag = {tag, " R8 stray start"};
      if (idx == 16'h0FFF || idx == 16'h0000) tag = {tag, " R10 edge index"};
      tag = {tag, " R9 R7"};
      check(tag, pins(),
            {e_rd, 8'd0, e_stby, e_trim, e_ce, e_clk, e_addr, e_busy, e_done, 1'b0, 5'b0});
      if (poke && c == 3) begin start = 1'b1; index = 16'h0123; end
      else start = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic reject_trace(input logic [15:0] idx);
    logic [DW-1:0] old = rdata;
    start = 1'b1; index = idx;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 6; c++) begin
      check("R6 rejected index", pins(),
            {old, 8'd0, 4'b0, 12'd0, (c == 1), 1'b0, (c == 1), 5'b0});
      @(negedge clk);
    end
  endtask

  task automatic idle_hold();
    logic [DW-1:0] old = rdata;
    repeat (20) @(negedge clk);
    check("R9 idle hold", {busy, rdata}, {1'b0, old});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", pins(), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset release", pins(), 64'd0);
    read_trace(16'h0100, 1'b0);
    read_trace(16'h0000, 1'b0);
    read_trace(16'h0FFF, 1'b0);
    idle_hold();
    reject_trace(16'h1000);
    reject_trace(16'hFFFF);
    read_trace(16'h0A5C, 1'b1);
    check("R8 stray start ignored", {busy, rdata}, {1'b0, fuse_word(12'hA5C)});
    idle_hold();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule